// File: doc/BRIEF.md
# Two-Stage Bark/Bite Watchdog

This block is a watchdog timer for a power-management controller, set up over a byte-wide register bus. Software programs two durations, counted in seconds: a warning interval and a grace interval. It also programs the kind of reset to request, and then turns the watchdog on. A one-cycle pulse on the seconds tick input advances the countdown. If software stops kicking the watchdog, the warning interval runs out first. The block then raises a bark interrupt and a matching status bit. If the grace interval also runs out, the block sends a single-cycle reset request together with the programmed reset kind.

The block also holds a small set of sticky shutdown-cause flags: watchdog reset, under-voltage lockout and over-temperature. The watchdog reset request does not clear them, so software can read them after the reboot. Only the power-on reset input, or a write of one to a flag, clears that flag. Timer values written during a countdown are stored and take effect at the next kick or enable.

Top module: `wdt_bark_bite`

## Requirements
- R1: After power-on reset (`rst_n` low), offset 0x54 reads 32, offset 0x55 reads 0, offset 0x56 reads 7, offset 0x57 reads 0, offsets 0x0C, 0x0D and 0x10 read 0, and `bark_irq` and `rst_req` are low.
- R2: Writing 0x57 with bit 7 set while the watchdog is off loads both stage durations and starts stage one, and bit 7 then reads back 1. Writing bit 7 as 0 stops counting and clears the bark, and ticks then have no effect.
- R3: Stage one lasts N ticks, where N is the value of 0x54 (1 to 127). `bark_irq` and bit 6 of offset 0x10 go high on the N-th tick and not before.
- R4: Stage two lasts M ticks, where M is the value of 0x55. `rst_req` is high for exactly one cycle on the M-th tick after the bark. With M = 0, `rst_req` fires on the tick that ends stage one, and no bark is shown.
- R5: `rst_kind` equals the low three bits of 0x56 while `rst_req` is high, and holds that value until the next reset request. The codes are 1 for warm reset, 4 for shutdown and 7 for hard reset.
- R6: After a reset request, the watchdog is off (0x57 bit 7 reads 0), `bark_irq` is low, and bit 2 of offset 0x0C reads 1.
- R7: While the watchdog is on, a write to 0x58 with bit 0 set restarts stage one with fresh durations. It clears the bark and cancels a pending reset. A write to 0x58 with bit 0 clear, or any write to 0x58 while the watchdog is off, has no effect.
- R8: Writes to 0x54 and 0x55 during a countdown do not change that countdown. The new values apply from the next kick or enable.
- R9: Bit 5 of 0x0D is set by a pulse on `uvlo_evt`, and bit 6 of 0x0D by a pulse on `otemp_evt`. These bits, and bit 2 of 0x0C, stay set until a write of 1 to that bit or a power-on reset. A set and a clear in the same cycle leave the bit set.
- R10: `bus_rdata` is 0 when `bus_rd` is low, and 0 for any unmapped offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, clears everything including the sticky flags |
| sec_tick | input | 1 | One-cycle pulse once per second |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read enable |
| bus_addr | input | AW (8) | Register offset |
| bus_wdata | input | DW (8) | Write data |
| bus_rdata | output | DW (8) | Read data, combinational from offset |
| uvlo_evt | input | 1 | Under-voltage lockout event pulse |
| otemp_evt | input | 1 | Over-temperature shutdown event pulse |
| bark_irq | output | 1 | Stage-one expiry interrupt, level |
| rst_req | output | 1 | One-cycle reset request |
| rst_kind | output | KW (3) | Reset kind captured at the request |

## Verification
A register write, kick or tick sampled at one rising edge changes the countdown state at that edge. So `bark_irq`, `rst_req`, `rst_kind` and the enable bit are all due one edge after the stimulus. The sticky watchdog flag is set from the registered reset request, so it appears one edge later still. The bench drives every input at a falling edge and samples half a cycle after the edge that should have acted. Reads are combinational, so they are sampled within the same low phase. A sweep over several stage-one and stage-two durations and all three reset kinds checks each result one tick before it is due and on the tick that makes it due.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ONE  = 2'd1,
        ST_TWO  = 2'd2
    } stage_e;

    // Offsets and bit positions that software depends on
    localparam int OFS_STATUS   = 'h10;
    localparam int OFS_CAUSE_A  = 'h0C;
    localparam int OFS_CAUSE_B  = 'h0D;
    localparam int OFS_WARN_T   = 'h54;
    localparam int OFS_GRACE_T  = 'h55;
    localparam int OFS_KIND     = 'h56;
    localparam int OFS_CTRL     = 'h57;
    localparam int OFS_KICK     = 'h58;

    localparam int BIT_BARK  = 6;
    localparam int BIT_WDOG  = 2;
    localparam int BIT_UVLO  = 5;
    localparam int BIT_OTEMP = 6;
    localparam int BIT_EN    = 7;
    localparam int BIT_KICK  = 0;

    // Flag vector indices
    localparam int FL_WDOG  = 0;
    localparam int FL_UVLO  = 1;
    localparam int FL_OTEMP = 2;
    localparam int FL_NUM   = 3;
endpackage

// File: rtl/wdt_stage_ctr.sv
module wdt_stage_ctr
    import wdt_pkg::*;
#(
    parameter int CW = 8,
    parameter int KW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          start_i,
    input  logic          tick_i,
    input  logic [CW-1:0] warn_i,
    input  logic [CW-1:0] grace_i,
    input  logic [KW-1:0] kind_i,
    output logic          bark_o,
    output logic          bite_o,
    output logic [KW-1:0] kind_o
);
    typedef struct packed {
        stage_e        stage;
        logic [CW-1:0] cnt;
        logic [CW-1:0] grace;
        logic          bark;
        logic          bite;
        logic [KW-1:0] kind;
    } ctr_t;

    localparam logic [CW-1:0] ONE = CW'(1);

    ctr_t ctr_d, ctr_q;

    always_comb begin
        logic expire;
        ctr_d      = ctr_q;
        ctr_d.bite = 1'b0;
        expire     = 1'b0;
        if (!en_i) begin
            ctr_d.stage = ST_IDLE;
            ctr_d.bark  = 1'b0;
        end else if (start_i) begin
            ctr_d.stage = ST_ONE;
            ctr_d.cnt   = warn_i;
            ctr_d.grace = grace_i;
            ctr_d.bark  = 1'b0;
        end else if (tick_i) begin
            unique case (ctr_q.stage)
                ST_ONE: begin
                    if (ctr_q.cnt > ONE) begin
                        ctr_d.cnt = ctr_q.cnt - ONE;
                    end else if (ctr_q.grace == '0) begin
                        expire = 1'b1;
                    end else begin
                        ctr_d.stage = ST_TWO;
                        ctr_d.cnt   = ctr_q.grace;
                        ctr_d.bark  = 1'b1;
                    end
                end
                ST_TWO: begin
                    if (ctr_q.cnt > ONE) ctr_d.cnt = ctr_q.cnt - ONE;
                    else                 expire    = 1'b1;
                end
                default: ;
            endcase
        end
        if (expire) begin
            ctr_d.bite  = 1'b1;
            ctr_d.stage = ST_IDLE;
            ctr_d.bark  = 1'b0;
            ctr_d.kind  = kind_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr_q <= '{stage: ST_IDLE, cnt: '0, grace: '0, bark: 1'b0,
                       bite: 1'b0, kind: '0};
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign bark_o = ctr_q.bark;
    assign bite_o = ctr_q.bite;
    assign kind_o = ctr_q.kind;

    // R4: reset request lasts one cycle
    a_r4_bite_single: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_q.bite |=> !ctr_q.bite);
    // R3: the bark only starts on a tick
    a_r3_bark_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctr_q.bark) |-> $past(tick_i));
    // R7, R2: the bark only ends on a kick, a disable or a bite
    a_r7_bark_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctr_q.bark) |-> ($past(start_i) || $past(!en_i) || ctr_q.bite));
    // R2: an idle counter never barks
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_q.stage == ST_IDLE) |-> !ctr_q.bark);
endmodule

// File: rtl/wdt_sticky.sv
module wdt_sticky #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] flag_d, flag_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_comb flag_d[i] = set_i[i] | (flag_q[i] & ~clr_i[i]);

        // R9: a set event always lands
        a_r9_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> flag_q[i]);
        // R9: a flag drops only on a clear write
        a_r9_clear_only: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flag_q[i]) |-> $past(clr_i[i]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/wdt_bark_bite.sv
module wdt_bark_bite
    import wdt_pkg::*;
#(
    parameter int DW       = 8,
    parameter int AW       = 8,
    parameter int KW       = 3,
    parameter int DEF_WARN = 32,
    parameter int DEF_GRACE = 0,
    parameter int DEF_KIND = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sec_tick,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          uvlo_evt,
    input  logic          otemp_evt,
    output logic          bark_irq,
    output logic          rst_req,
    output logic [KW-1:0] rst_kind
);
    typedef struct packed {
        logic [DW-1:0] warn;
        logic [DW-1:0] grace;
        logic [KW-1:0] kind;
        logic          en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic start, kick;
    logic bark, bite;
    logic [KW-1:0]     kind_at_bite;
    logic [FL_NUM-1:0] flag_set, flag_clr, flags;

    function automatic logic wr_at(input logic [AW-1:0] a, input int ofs,
                                   input logic strobe);
        return strobe && (a == AW'(ofs));
    endfunction

    always_comb begin
        logic arm;
        cfg_d = cfg_q;
        if (wr_at(bus_addr, OFS_WARN_T, bus_wr))  cfg_d.warn  = bus_wdata;
        if (wr_at(bus_addr, OFS_GRACE_T, bus_wr)) cfg_d.grace = bus_wdata;
        if (wr_at(bus_addr, OFS_KIND, bus_wr))    cfg_d.kind  = bus_wdata[KW-1:0];
        if (wr_at(bus_addr, OFS_CTRL, bus_wr))    cfg_d.en    = bus_wdata[BIT_EN];
        if (bite) cfg_d.en = 1'b0;

        kick  = wr_at(bus_addr, OFS_KICK, bus_wr) && bus_wdata[BIT_KICK]
                && cfg_q.en && !bite;
        arm   = wr_at(bus_addr, OFS_CTRL, bus_wr) && bus_wdata[BIT_EN]
                && !cfg_q.en && !bite;
        start = kick || arm;

        flag_set           = '0;
        flag_set[FL_WDOG]  = bite;
        flag_set[FL_UVLO]  = uvlo_evt;
        flag_set[FL_OTEMP] = otemp_evt;
        flag_clr           = '0;
        flag_clr[FL_WDOG]  = wr_at(bus_addr, OFS_CAUSE_A, bus_wr) && bus_wdata[BIT_WDOG];
        flag_clr[FL_UVLO]  = wr_at(bus_addr, OFS_CAUSE_B, bus_wr) && bus_wdata[BIT_UVLO];
        flag_clr[FL_OTEMP] = wr_at(bus_addr, OFS_CAUSE_B, bus_wr) && bus_wdata[BIT_OTEMP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{warn: DW'(DEF_WARN), grace: DW'(DEF_GRACE),
                       kind: KW'(DEF_KIND), en: 1'b0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    wdt_stage_ctr #(.CW(DW), .KW(KW)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (cfg_d.en),
        .start_i (start),
        .tick_i  (sec_tick),
        .warn_i  (cfg_q.warn),
        .grace_i (cfg_q.grace),
        .kind_i  (cfg_q.kind),
        .bark_o  (bark),
        .bite_o  (bite),
        .kind_o  (kind_at_bite)
    );

    wdt_sticky #(.N(FL_NUM)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (flag_set),
        .clr_i  (flag_clr),
        .flag_o (flags)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (int'(bus_addr))
                OFS_STATUS:  bus_rdata[BIT_BARK]  = bark;
                OFS_CAUSE_A: bus_rdata[BIT_WDOG]  = flags[FL_WDOG];
                OFS_CAUSE_B: begin
                    bus_rdata[BIT_UVLO]  = flags[FL_UVLO];
                    bus_rdata[BIT_OTEMP] = flags[FL_OTEMP];
                end
                OFS_WARN_T:  bus_rdata = cfg_q.warn;
                OFS_GRACE_T: bus_rdata = cfg_q.grace;
                OFS_KIND:    bus_rdata = DW'(cfg_q.kind);
                OFS_CTRL:    bus_rdata[BIT_EN] = cfg_q.en;
                default:     bus_rdata = '0;
            endcase
        end
    end

    assign bark_irq = bark;
    assign rst_req  = bite;
    assign rst_kind = kind_at_bite;

    // R6: a reset request leaves the watchdog off with its cause recorded
    a_r6_after_bite: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> (!cfg_q.en && flags[FL_WDOG] && !bark_irq));
    // R7: a kick clears any bark
    a_r7_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !bark_irq);
    // R2: no bark while the watchdog is off
    a_r2_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.en |-> (!bark_irq || $past(cfg_q.en)));
    // R5: the reset kind only changes with a reset request
    a_r5_kind_held: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_req |-> $stable(rst_kind));
endmodule

// File: tb/sim_wdt_bark_bite.sv
`timescale 1ns/1ps
module sim_wdt_bark_bite;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       uvlo_evt = 1'b0;
    logic       otemp_evt = 1'b0;
    logic       bark_irq, rst_req;
    logic [2:0] rst_kind;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    wdt_bark_bite u0 (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .uvlo_evt(uvlo_evt), .otemp_evt(otemp_evt),
        .bark_irq(bark_irq), .rst_req(rst_req), .rst_kind(rst_kind)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act %0d exp %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'(a); bus_wdata = 8'(d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 8'(a);
        #1;
        v = int'(bus_rdata);
        bus_rd = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic por();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired act 0 exp 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int v;
        int kinds[3] = '{1, 4, 7};
        int warns[4] = '{1, 2, 3, 5};
        int graces[4] = '{0, 1, 2, 3};
        int idx = 0;

        por();
        // R1 reset state
        rd('h54, v); chk("R1 warn default", v, 32);
        rd('h55, v); chk("R1 grace default", v, 0);
        rd('h56, v); chk("R1 kind default", v, 7);
        rd('h57, v); chk("R1 ctrl default", v, 0);
        rd('h0C, v); chk("R1 cause A", v, 0);
        rd('h0D, v); chk("R1 cause B", v, 0);
        rd('h10, v); chk("R1 status", v, 0);
        chk("R1 bark", int'(bark_irq), 0);
        chk("R1 rst_req", int'(rst_req), 0);

        // Sweep of stage durations and reset kinds: R2 R3 R4 R5 R6
        foreach (warns[i]) begin
            foreach (graces[j]) begin
                int k = kinds[idx % 3];
                idx++;
                wr('h54, warns[i]);
                wr('h55, graces[j]);
                wr('h56, k);
                wr('h57, 'h80);
                rd('h57, v); chk("R2 enable reads", v, 'h80);
                for (int t = 1; t < warns[i]; t++) tick();
                chk("R3 no early bark", int'(bark_irq), 0);
                tick();
                if (graces[j] > 0) begin
                    chk("R3 bark on tick N", int'(bark_irq), 1);
                    chk("R4 no early req", int'(rst_req), 0);
                    rd('h10, v); chk("R3 status bit", v, 'h40);
                    for (int t = 1; t < graces[j]; t++) tick();
                    chk("R4 no early req2", int'(rst_req), 0);
                    tick();
                end else begin
                    chk("R4 zero grace no bark", int'(bark_irq), 0);
                end
                chk("R4 rst_req", int'(rst_req), 1);
                chk("R5 rst_kind", int'(rst_kind), k);
                @(negedge clk);
                chk("R4 single pulse", int'(rst_req), 0);
                chk("R5 kind held", int'(rst_kind), k);
                chk("R6 bark cleared", int'(bark_irq), 0);
                rd('h57, v); chk("R6 disabled", v, 0);
                rd('h0C, v); chk("R6 wdog cause", v, 'h04);
                wr('h0C, 'h04);
                rd('h0C, v); chk("R9 w1c wdog", v, 0);
            end
        end

        // R7 kick during stage two cancels the reset
        wr('h54, 2); wr('h55, 3); wr('h56, 1); wr('h57, 'h80);
        tick(); tick();
        chk("R7 bark before kick", int'(bark_irq), 1);
        tick();
        wr('h58, 'h01);
        chk("R7 kick clears bark", int'(bark_irq), 0);
        tick(); chk("R7 restarted", int'(bark_irq), 0);
        tick(); chk("R7 bark again", int'(bark_irq), 1);
        tick(); chk("R7 no req", int'(rst_req), 0);
        tick(); chk("R7 no req2", int'(rst_req), 0);
        tick(); chk("R7 req after full grace", int'(rst_req), 1);
        @(negedge clk);

        // R7 kick with bit 0 clear is ignored
        wr('h57, 'h80);
        tick();
        wr('h58, 'h00);
        tick(); chk("R7 zero kick ignored", int'(bark_irq), 1);

        // R2 disable stops counting and clears bark
        wr('h57, 'h00);
        chk("R2 disable clears bark", int'(bark_irq), 0);
        rd('h57, v); chk("R2 ctrl off", v, 0);
        for (int t = 0; t < 5; t++) tick();
        chk("R2 no bark while off", int'(bark_irq), 0);
        chk("R2 no req while off", int'(rst_req), 0);
        wr('h58, 'h01);
        for (int t = 0; t < 3; t++) tick();
        chk("R7 kick while off ignored", int'(bark_irq), 0);
        rd('h57, v); chk("R7 still off", v, 0);

        // R8 timer writes during a countdown
        wr('h54, 3); wr('h55, 1); wr('h57, 'h80);
        wr('h54, 1);
        tick(); chk("R8 old warn kept", int'(bark_irq), 0);
        tick(); chk("R8 old warn kept2", int'(bark_irq), 0);
        tick(); chk("R8 old warn expiry", int'(bark_irq), 1);
        wr('h55, 2);
        tick(); chk("R8 old grace kept", int'(rst_req), 1);
        @(negedge clk);
        wr('h57, 'h80);
        tick(); chk("R8 new warn used", int'(bark_irq), 1);
        tick(); chk("R8 new grace no req", int'(rst_req), 0);
        tick(); chk("R8 new grace req", int'(rst_req), 1);
        @(negedge clk);

        // R9 sticky cause flags
        @(negedge clk); uvlo_evt = 1'b1;
        @(negedge clk); uvlo_evt = 1'b0;
        rd('h0D, v); chk("R9 uvlo set", v, 'h20);
        @(negedge clk); otemp_evt = 1'b1;
        @(negedge clk); otemp_evt = 1'b0;
        rd('h0D, v); chk("R9 otemp set", v, 'h60);
        wr('h0D, 'h20);
        rd('h0D, v); chk("R9 w1c uvlo", v, 'h40);
        @(negedge clk);
        otemp_evt = 1'b1;
        bus_wr = 1'b1; bus_addr = 8'h0D; bus_wdata = 8'h40;
        @(negedge clk);
        otemp_evt = 1'b0; bus_wr = 1'b0;
        rd('h0D, v); chk("R9 set wins", v, 'h40);
        rd('h0C, v); chk("R9 wdog flag sticky", v, 'h04);
        por();
        rd('h0D, v); chk("R9 por clears B", v, 0);
        rd('h0C, v); chk("R9 por clears A", v, 0);

        // R10 read gating and unmapped offsets
        rd('h33, v); chk("R10 unmapped", v, 0);
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = 8'h54;
        #1; chk("R10 rd low", int'(bus_rdata), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule